// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM of 16-bit words addressed by an 18-bit word address. The host presents one access at a time through a valid/ready handshake: a direction bit, an address, write data and a byte mask. Reads return their data with a one-cycle valid pulse. On the memory side the block generates active-low chip select, write strobe, output enable and one active-low enable per byte lane. It also provides a split data bus (drive value, drive enable, sampled input) for a tristate pad that lives outside the block.

Every phase of an access is timed by counting host clock cycles. The counts are parameters, so they can be sized against the memory's access time and strobe-width limits at the chosen clock rate. A write is ended by the rising write strobe while chip select is still low. The controller drives the data bus from one cycle before the strobe falls until one cycle after it rises. After every read, the bus is given a quiet cycle before the controller may drive it again. After reset the block stays deselected until a power-up wait has elapsed.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset release, req_ready stays low and mem_ce_n stays high for at least STARTUP_CYC and at most STARTUP_CYC+1 cycles; during reset req_ready=0, mem_ce_n=1, mem_dq_oe=0.
- R2: Whenever req_ready is high, mem_ce_n, mem_we_n, mem_oe_n and every bit of mem_be_n are 1 and mem_dq_oe is 0.
- R3: A request is taken on a rising edge where req_valid and req_ready are both 1; req_ready is 0 in the cycle after acceptance and stays 0 while mem_ce_n is 0.
- R4: In a write, mem_ce_n is low for exactly SETUP_CYC cycles with mem_we_n high before mem_we_n falls; mem_we_n is then low for exactly WR_PULSE_CYC cycles, with mem_ce_n low and mem_oe_n high throughout.
- R5: mem_dq_oe is 1 in the cycle before mem_we_n falls and in the first cycle after mem_we_n rises, is 0 in the cycle after that, and is never 1 while mem_oe_n is 0.
- R6: req_bmask bit 0 selects data bits 7:0 through mem_be_n[0] and bit 1 selects bits 15:8 through mem_be_n[1] (enable = 0). A lane whose mask bit is 0 keeps its enable at 1, so a write leaves the stored byte unchanged.
- R7: In a read, mem_ce_n and mem_oe_n are low and mem_we_n is high; rsp_valid is a one-cycle pulse whose rising edge comes exactly RD_WAIT_CYC clock edges after the accepting edge and carries the stored word.
- R8: In rsp_rdata, any byte lane whose mask bit was 0 reads as zero.
- R9: After a read, req_ready returns exactly TURN_CYC cycles after the cycle in which rsp_valid is high, and mem_dq_oe is never 1 in the cycle after one with mem_oe_n low.
- R10: While mem_ce_n stays low, mem_addr holds the accepted address and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host presents an access |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Value for the pad to drive |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_in | input | 16 | Value sampled from the pad |

## Verification
The assertions assume that the host holds a request stable while req_valid is high and waits for req_ready. They also assume that mem_dq_in is valid by the last read-wait cycle, which the memory model in the bench guarantees by answering at once from its address. The driver never changes a request until it has been taken, and it presents the next request only once req_ready is back. Address checks against the accepted request therefore stay in step with the design. The memory model drives filler bytes on disabled lanes so that a missing read mask shows up.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_RWAIT,
      ST_RTURN
   } seq_state_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } strobe_t;

   function automatic strobe_t strobe_of(seq_state_e s);
      strobe_t t;
      t = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
      case (s)
         ST_WSETUP: begin t.ce_n = 1'b0; t.drive = 1'b1; end
         ST_WPULSE: begin t.ce_n = 1'b0; t.we_n = 1'b0; t.drive = 1'b1; end
         ST_WHOLD:  begin t.ce_n = 1'b0; t.drive = 1'b1; end
         ST_RWAIT:  begin t.ce_n = 1'b0; t.oe_n = 1'b0; end
         default:   ;
      endcase
      return t;
   endfunction

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sram_ctrl_wake.sv
module sram_ctrl_wake #(
   parameter int unsigned WAIT_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);

   generate
      if (WAIT_CYC == 0) begin : g_nowait
         assign done = 1'b1;
      end else begin : g_count
         localparam int unsigned W = $clog2(WAIT_CYC + 1);
         localparam logic [W-1:0] LIMIT = W'(WAIT_CYC);
         logic [W-1:0] ticks;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ticks <= '0;
            else if (ticks != LIMIT) ticks <= ticks + 1'b1;
         end

         assign done = (ticks == LIMIT);

         AST_WAKE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> done); // R1
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
   parameter int unsigned LANES = 2
) (
   input  logic               sel_n,
   input  logic [LANES-1:0]   mask,
   input  logic [LANES*8-1:0] rd_raw,
   output logic [LANES-1:0]   lane_n,
   output logic [LANES*8-1:0] rd_masked
);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign lane_n[l]          = sel_n | ~mask[l];
         assign rd_masked[l*8 +: 8] = mask[l] ? rd_raw[l*8 +: 8] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned SETUP_CYC    = 1,
   parameter int unsigned WR_PULSE_CYC = 1,
   parameter int unsigned RD_WAIT_CYC  = 2,
   parameter int unsigned TURN_CYC     = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    boot_done,
   input  logic    req_fire,
   input  logic    req_write,
   output logic    idle,
   output logic    capture,
   output strobe_t strb
);

   localparam int unsigned MAXC  = max4(SETUP_CYC, WR_PULSE_CYC, RD_WAIT_CYC, TURN_CYC);
   localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

   seq_state_e       state, nxt;
   logic [CNT_W-1:0] cnt, nxt_cnt;
   logic             last;

   assign last = (cnt == '0);
   assign idle = (state == ST_IDLE);

   always_comb begin
      nxt     = state;
      nxt_cnt = last ? cnt : cnt - 1'b1;
      capture = 1'b0;
      case (state)
         ST_BOOT: if (boot_done) nxt = ST_IDLE;
         ST_IDLE: begin
            if (req_fire) begin
               if (req_write) begin
                  nxt     = ST_WSETUP;
                  nxt_cnt = CNT_W'(SETUP_CYC - 1);
               end else begin
                  nxt     = ST_RWAIT;
                  nxt_cnt = CNT_W'(RD_WAIT_CYC - 1);
               end
            end
         end
         ST_WSETUP: if (last) begin
            nxt     = ST_WPULSE;
            nxt_cnt = CNT_W'(WR_PULSE_CYC - 1);
         end
         ST_WPULSE: if (last) begin
            nxt     = ST_WHOLD;
            nxt_cnt = '0;
         end
         ST_WHOLD: nxt = ST_IDLE;
         ST_RWAIT: if (last) begin
            capture = 1'b1;
            nxt     = ST_RTURN;
            nxt_cnt = CNT_W'(TURN_CYC - 1);
         end
         ST_RTURN: if (last) nxt = ST_IDLE;
         default:  nxt = ST_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_BOOT;
         cnt   <= '0;
         strb  <= strobe_of(ST_BOOT);
      end else begin
         state <= nxt;
         cnt   <= nxt_cnt;
         strb  <= strobe_of(nxt);
      end
   end

   AST_PULSE_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WPULSE) |-> ($past(state) == ST_WSETUP || $past(state) == ST_WPULSE)); // R4
   AST_TURN_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_RWAIT && state != ST_RWAIT) |-> (state == ST_RTURN)); // R9

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 18,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned STARTUP_CYC  = 125,
   parameter int unsigned SETUP_CYC    = 1,
   parameter int unsigned WR_PULSE_CYC = 1,
   parameter int unsigned RD_WAIT_CYC  = 2,
   parameter int unsigned TURN_CYC     = 1,
   localparam int unsigned LANES       = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_bmask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   generate
      if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_width
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (SETUP_CYC == 0 || WR_PULSE_CYC == 0 || RD_WAIT_CYC == 0 || TURN_CYC == 0) begin : g_bad_count
         $error("phase counts must be at least one cycle");
      end
   endgenerate

   logic              boot_done;
   logic              idle;
   logic              capture;
   logic              req_fire;
   strobe_t           strb;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic [DATA_W-1:0] rd_masked;
   logic [DATA_W-1:0] rdata_q;
   logic              rsp_q;

   assign req_ready = idle;
   assign req_fire  = req_valid & idle;

   sram_ctrl_wake #(.WAIT_CYC(STARTUP_CYC)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (boot_done)
   );

   sram_ctrl_seq #(
      .SETUP_CYC    (SETUP_CYC),
      .WR_PULSE_CYC (WR_PULSE_CYC),
      .RD_WAIT_CYC  (RD_WAIT_CYC),
      .TURN_CYC     (TURN_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_done (boot_done),
      .req_fire  (req_fire),
      .req_write (req_write),
      .idle      (idle),
      .capture   (capture),
      .strb      (strb)
   );

   sram_ctrl_lanes #(.LANES(LANES)) u_lanes (
      .sel_n     (strb.ce_n),
      .mask      (mask_q),
      .rd_raw    (mem_dq_in),
      .lane_n    (mem_be_n),
      .rd_masked (rd_masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (req_fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_bmask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= capture;
         if (capture) rdata_q <= rd_masked;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_ce_n   = strb.ce_n;
   assign mem_we_n   = strb.we_n;
   assign mem_oe_n   = strb.oe_n;
   assign mem_dq_oe  = strb.drive;
   assign mem_dq_out = wdata_q;
   assign rsp_valid  = rsp_q;
   assign rsp_rdata  = rdata_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n))); // R2
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready); // R3
   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R4
   AST_DRIVE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_dq_oe)); // R5
   AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe); // R5
   AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R5
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7
   AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |=> !mem_dq_oe); // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

   localparam int unsigned STARTUP = 30;
   localparam int unsigned SETUP   = 1;
   localparam int unsigned PULSE   = 1;
   localparam int unsigned RDWAIT  = 2;
   localparam int unsigned TURN    = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_bmask = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [17:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_dq_out;
   logic [15:0] mem_dq_in;

   always #4 clk = ~clk;

   sram_bus_ctrl #(
      .STARTUP_CYC(STARTUP), .SETUP_CYC(SETUP), .WR_PULSE_CYC(PULSE),
      .RD_WAIT_CYC(RDWAIT), .TURN_CYC(TURN)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit armed  = 1'b0;

   always @(posedge clk) cyc++;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model
   logic [15:0] sram [int];
   logic [15:0] rd_word = '0;
   bit          pend = 1'b0;
   logic [17:0] p_addr;
   logic [15:0] p_data;
   logic [1:0]  p_be_n;

   function automatic logic [15:0] peek(logic [17:0] a);
      if (sram.exists(int'(a))) return sram[int'(a)];
      return 16'h0000;
   endfunction

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
      {mem_be_n[1] ? 8'hA5 : rd_word[15:8], mem_be_n[0] ? 8'hA5 : rd_word[7:0]} : 16'hDEAD;

   always @(negedge clk) begin
      rd_word <= peek(mem_addr);
      if (!mem_ce_n && !mem_we_n) begin
         pend   <= 1'b1;
         p_addr <= mem_addr;
         p_data <= mem_dq_out;
         p_be_n <= mem_be_n;
      end else if (pend) begin
         logic [15:0] w;
         w = peek(p_addr);
         if (!p_be_n[0]) w[7:0]  = p_data[7:0];
         if (!p_be_n[1]) w[15:8] = p_data[15:8];
         sram[int'(p_addr)] = w;
         pend <= 1'b0;
      end
   end

   // expected state
   logic [15:0] shadow [int];
   typedef struct { logic [15:0] data; int acc; } exp_t;
   exp_t        expq[$];
   logic [17:0] cur_addr = '0;
   logic [1:0]  cur_mask = '0;

   function automatic logic [15:0] sh(logic [17:0] a);
      if (shadow.exists(int'(a))) return shadow[int'(a)];
      return 16'h0000;
   endfunction

   task automatic issue(bit wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_addr  = a;
      cur_mask  = m;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_bmask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R3", "ready after accept", int'(req_ready), 0);
      if (wr) begin
         logic [15:0] w;
         w = sh(a);
         if (m[0]) w[7:0]  = d[7:0];
         if (m[1]) w[15:8] = d[15:8];
         shadow[int'(a)] = w;
      end else begin
         exp_t e;
         e.data = {m[1] ? sh(a)[15:8] : 8'h00, m[0] ? sh(a)[7:0] : 8'h00};
         e.acc  = cyc;
         expq.push_back(e);
      end
   endtask

   // monitor
   logic prev_we_n = 1'b1, prev_oe_n = 1'b1, after_rise = 1'b0;
   int   ce_run = 0, we_run = 0, turn_cnt = 0;
   bit   turn_arm = 1'b0;

   always @(negedge clk) begin
      if (rst_n && armed) begin
         if (req_ready)
            chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && mem_be_n == 2'b11,
                "R2", "idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'hE);
         if (!mem_ce_n) begin
            ce_run++;
            chk(mem_addr == cur_addr, "R10", "address held", int'(mem_addr), int'(cur_addr));
         end else ce_run = 0;
         if (!mem_we_n) begin
            we_run++;
            chk(!mem_ce_n && mem_oe_n, "R4", "ce low oe high in pulse", {mem_ce_n, mem_oe_n}, 2'b01);
            chk(mem_be_n == ~cur_mask, "R6", "lane enables", int'(mem_be_n), int'(~cur_mask));
            if (prev_we_n) begin
               chk(ce_run == SETUP + 1, "R4", "setup cycles", ce_run - 1, SETUP);
               chk(mem_dq_oe, "R5", "drive at strobe fall", int'(mem_dq_oe), 1);
            end
         end
         if (after_rise) begin
            chk(!mem_dq_oe, "R5", "release after hold", int'(mem_dq_oe), 0);
            after_rise = 1'b0;
         end
         if (mem_we_n && !prev_we_n) begin
            chk(we_run == PULSE, "R4", "strobe width", we_run, PULSE);
            chk(mem_dq_oe, "R5", "drive after strobe rise", int'(mem_dq_oe), 1);
            we_run = 0;
            after_rise = 1'b1;
         end
         if (mem_dq_oe)
            chk(mem_oe_n && prev_oe_n, "R9", "no drive near oe low", {prev_oe_n, mem_oe_n}, 2'b11);
         if (turn_arm) begin
            if (req_ready) begin
               chk(turn_cnt == TURN, "R9", "turnaround length", turn_cnt, TURN);
               turn_arm = 1'b0;
            end else turn_cnt++;
         end
         if (rsp_valid) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R7", "unexpected response", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               chk(rsp_rdata == e.data, "R7 R8", "read data", int'(rsp_rdata), int'(e.data));
               chk(cyc - e.acc == RDWAIT, "R7", "read latency", cyc - e.acc, RDWAIT);
            end
            turn_arm = 1'b1;
            turn_cnt = 1;
         end
         prev_we_n = mem_we_n;
         prev_oe_n = mem_oe_n;
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      chk(!req_ready && mem_ce_n && !mem_dq_oe, "R1", "reset state",
          {req_ready, mem_ce_n, mem_dq_oe}, 3'b010);
      rst_n = 1'b1;
      n = 0;
      while (!req_ready && n < STARTUP + 10) begin
         chk(mem_ce_n, "R1", "deselected during wait", int'(mem_ce_n), 1);
         @(negedge clk);
         n++;
      end
      chk(n >= STARTUP && n <= STARTUP + 1, "R1", "startup wait", n, STARTUP);
      armed = 1'b1;

      issue(1, 18'h00000, 16'hA5C3, 2'b11);
      issue(0, 18'h00000, 16'h0000, 2'b11);            // R7
      issue(1, 18'h3FFFF, 16'h1234, 2'b11);
      issue(0, 18'h3FFFF, 16'h0000, 2'b11);
      issue(0, 18'h3FFFF, 16'h0000, 2'b01);            // R8 upper zero
      issue(0, 18'h3FFFF, 16'h0000, 2'b10);            // R8 lower zero
      issue(1, 18'h3FFFF, 16'hBEEF, 2'b01);            // R6 lower only
      issue(0, 18'h3FFFF, 16'h0000, 2'b11);
      issue(1, 18'h00000, 16'h77AA, 2'b10);            // R6 upper only
      issue(0, 18'h00000, 16'h0000, 2'b11);
      issue(1, 18'h00100, 16'h5555, 2'b11);
      issue(1, 18'h00100, 16'hFFFF, 2'b00);            // R6 no lanes
      issue(0, 18'h00100, 16'h0000, 2'b11);
      for (int i = 1; i < 9; i++) begin
         issue(1, 18'(i * 18'h1111), 16'(i * 16'h0F1D + 16'h0301), 2'b11);
         issue(0, 18'((i - 1) * 18'h1111), 16'h0000, 2'(i % 4));
         issue(1, 18'(i * 18'h1111 + 1), 16'(~(i * 16'h1357)), 2'(3 - i % 3));   // R9 write after read
      end
      for (int i = 1; i < 9; i++) issue(0, 18'(i * 18'h1111 + 1), 16'h0000, 2'b11);

      n = 0;
      while ((expq.size() != 0 || !req_ready) && n < 100) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R7", "all reads answered", expq.size(), 0);
      summary();
      $finish;
   end

endmodule